// File: doc/BRIEF.md
# Periodic DRAM Refresh Request and Address Generator

This block paces DRAM refresh and supplies the 20-bit physical address for each refresh bus cycle. A programmable down-counting timer raises a refresh request at a fixed interval. The bus interface services the request and then pulses a completion strobe. That strobe clears the request and moves the row sequence on by one step.

The address has three parts. The top seven bits hold a software-written base value, and the middle twelve bits hold a row sequence. This sequence is a full-period shift-register counter: it visits all 4096 codes, including all-zeros, in a non-binary order. Bit 0 is fixed at one.

Requests are never queued. If the timer fires while a request is still pending, only one request stays outstanding. The lost request is counted in a saturating counter, which is exposed on a port so that the drop behaviour can be observed. The row address is not lost when a request is dropped, because the row changes only when a refresh cycle has actually run.

Top module: `refresh_addr_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it: `req` is 0, `ovr_count` is 0, `addr` is 20'h01FFF (base 0, row all ones, bit 0 one).
- R2: A cycle with `base_we` high loads `base_val`, which appears on `addr[19:13]` from the next clock on; without a write those bits hold.
- R3: `addr[0]` is 1 in every cycle.
- R4: `addr[12:1]` changes in the cycle after a cycle with `cyc_done` high and holds in every other cycle, so an unserviced request leaves the address unchanged.
- R5: Across 4096 consecutive `cyc_done` pulses after reset, `addr[12:1]` takes 4096 distinct values including 0, and it is back at 12'hFFF after the last one.
- R6: While `tmr_en` is low, the timer reloads from `period` and raises no request. While enabled, it counts down and fires when its count is 0, then reloads, so it fires once every `period`+1 cycles.
- R7: A timer firing sets `req` on the next clock. A `cyc_done` without a firing in the same cycle clears it on the next clock. When both happen in the same cycle, `req` stays 1.
- R8: When the timer fires while `req` is 1 and `cyc_done` is low, `req` stays a single level and `ovr_count` increments by one, saturating at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Base register write strobe |
| base_val | input | 7 | Base register write data |
| period | input | 16 | Timer reload value |
| tmr_en | input | 1 | Timer enable |
| cyc_done | input | 1 | Refresh bus cycle completed strobe |
| req | output | 1 | Refresh request level |
| addr | output | 20 | Refresh physical address |
| ovr_count | output | 8 | Saturating count of dropped requests |

## Verification
On every cycle, the assertions check the following: the row holds without a done strobe and moves with one, a base write lands on the next clock, a timer firing sets the request, and the overrun count increments or saturates. Other behaviours need whole scenarios in the bench. These are the exact timer spacing for a given period, a done strobe that coincides with a firing, and the full 4096-step row period with its single all-zero visit and return to the seed. The bench's cycle model compares request, overrun count and base bits on every clock.

// File: rtl/refgen_pkg.sv
package refgen_pkg;
    // Address geometry shared by all refresh-generator modules.
    localparam int BASE_W = 7;
    localparam int ROW_W  = 12;
    localparam int ADDR_W = BASE_W + ROW_W + 1;
    // Feedback mask for the 12-bit row sequence (bits 11,10,7,5).
    localparam logic [ROW_W-1:0] ROW_TAPS = 12'hCA0;
    localparam logic [ROW_W-1:0] ROW_SEED = '1;
endpackage

// File: rtl/refgen_timer.sv
module refgen_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [TMR_W-1:0] period,
    output logic             tick
);
    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = en && (st_q.cnt == '0);
        if (!en || tick) begin
            st_d.cnt = period;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    tick_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> en);
endmodule

// File: rtl/refgen_rowseq.sv
module refgen_rowseq
    import refgen_pkg::*;
#(
    parameter int               W    = ROW_W,
    parameter logic [W-1:0]     TAPS = ROW_TAPS,
    parameter logic [W-1:0]     SEED = ROW_SEED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] row
);
    typedef struct packed {
        logic [W-1:0] row;
    } row_state_t;

    row_state_t st_d, st_q;
    logic       fb;
    logic       low_zero;

    always_comb begin
        st_d     = st_q;
        low_zero = (st_q.row[W-2:0] == '0);
        // Linear feedback, flipped when all bits below the top are zero,
        // which splices the all-zero code into the maximal sequence.
        fb       = (^(st_q.row & TAPS)) ^ low_zero;
        if (step) begin
            st_d.row = {st_q.row[W-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.row <= SEED;
        else        st_q     <= st_d;
    end

    assign row = st_q.row;

    // R4
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(row));
    // R4
    row_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (row != $past(row)));
endmodule

// File: rtl/refresh_addr_gen.sv
module refresh_addr_gen
    import refgen_pkg::*;
#(
    parameter int TMR_W = 16,
    parameter int OVR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [BASE_W-1:0] base_val,
    input  logic [TMR_W-1:0]  period,
    input  logic              tmr_en,
    input  logic              cyc_done,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output logic [OVR_W-1:0]  ovr_count
);
    localparam logic [OVR_W-1:0] OVR_MAX = '1;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              req;
        logic [OVR_W-1:0]  ovr;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic             tick;
    logic [ROW_W-1:0] row;

    refgen_timer #(.TMR_W(TMR_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (tmr_en),
        .period (period),
        .tick   (tick)
    );

    refgen_rowseq u_rows (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (cyc_done),
        .row   (row)
    );

    always_comb begin
        st_d = st_q;
        if (base_we) st_d.base = base_val;
        // A firing while still pending and not serviced is dropped.
        if (tick && st_q.req && !cyc_done && (st_q.ovr != OVR_MAX)) begin
            st_d.ovr = st_q.ovr + 1'b1;
        end
        if (tick)          st_d.req = 1'b1;
        else if (cyc_done) st_d.req = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req       = st_q.req;
    assign ovr_count = st_q.ovr;
    assign addr      = {st_q.base, row, 1'b1};

    // R2
    base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |=> (addr[ADDR_W-1:ADDR_W-BASE_W] == $past(base_val)));
    // R7
    req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> req);
    // R8
    ovr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && req && !cyc_done && ovr_count != OVR_MAX)
        |=> (ovr_count == $past(ovr_count) + 1'b1));
    // R8
    ovr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_count == OVR_MAX) |=> (ovr_count == OVR_MAX));
endmodule

// File: tb/refresh_addr_gen_test.sv
module refresh_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_we = 1'b0;
    logic [6:0]  base_val = '0;
    logic [15:0] period = '0;
    logic        tmr_en = 1'b0;
    logic        cyc_done = 1'b0;
    logic        req;
    logic [19:0] addr;
    logic [7:0]  ovr_count;

    int n_vec = 0;
    int n_bad = 0;

    // behavioural reference state
    int          m_cnt = 0;
    bit          m_req = 0;
    int          m_ovr = 0;
    int          m_base = 0;
    bit          m_done_last = 0;
    int          prev_row = 0;
    bit          seen [0:4095];

    always #10ns clk = ~clk;

    refresh_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_val(base_val),
        .period(period), .tmr_en(tmr_en), .cyc_done(cyc_done),
        .req(req), .addr(addr), .ovr_count(ovr_count)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_req = 0; m_ovr = 0; m_base = 0; m_done_last = 0;
        end else begin
            bit fire;
            fire = tmr_en && (m_cnt == 0);
            if (!tmr_en || fire) m_cnt = period;
            else                 m_cnt = m_cnt - 1;
            if (fire && m_req && !cyc_done && m_ovr < 255) m_ovr = m_ovr + 1;
            if (fire)          m_req = 1;
            else if (cyc_done) m_req = 0;
            if (base_we) m_base = base_val;
            m_done_last = cyc_done;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // compare at the falling edge, after all register updates have settled
    task automatic cycle();
        @(negedge clk);
        chk("R3 addr bit0", int'(addr[0]), 1);
        chk("R2 base bits", int'(addr[19:13]), m_base);
        chk("R6/R7 req", int'(req), int'(m_req));
        chk("R8 ovr_count", int'(ovr_count), m_ovr);
        if (m_done_last) begin
            n_vec++;
            if (int'(addr[12:1]) == prev_row) begin
                n_bad++;
                $display("FAIL R4 row did not step: actual %0h expected != %0h",
                         addr[12:1], prev_row);
            end
        end else begin
            chk("R4 row hold", int'(addr[12:1]), prev_row);
        end
        prev_row = int'(addr[12:1]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; base_we = 0; cyc_done = 0; tmr_en = 0;
        @(negedge clk);
        chk("R1 reset req", int'(req), 0);
        chk("R1 reset addr", int'(addr), 20'h01FFF);
        chk("R1 reset ovr", int'(ovr_count), 0);
        prev_row = 12'hFFF;
        rst_n = 1'b1;
        cycle();
        chk("R1 post-reset addr", int'(addr), 20'h01FFF);
    endtask

    initial begin
        #(200000 * 20ns);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        do_reset();

        // R2: base writes of several patterns, with idle gaps
        foreach (seen[i]) seen[i] = 0;
        for (int k = 0; k < 4; k++) begin
            base_we = 1; base_val = 7'(k * 37 + 5);
            cycle();
            base_we = 0; base_val = 7'h7F;
            cycle();
            cycle();
        end

        // R6/R8: period 5, no service, requests pile up and are dropped
        period = 16'd5; tmr_en = 1;
        for (int k = 0; k < 25; k++) cycle();
        // R4: request pending but no done, row must hold (checked in cycle)
        // R7: service with spaced done pulses
        for (int k = 0; k < 30; k++) begin
            cyc_done = (k % 4 == 1);
            cycle();
        end
        cyc_done = 0;

        // R7: done coinciding with a firing keeps req set (period 3)
        period = 16'd3; tmr_en = 0; cycle();
        tmr_en = 1;
        for (int k = 0; k < 24; k++) begin
            cyc_done = (k % 4 == 0);
            cycle();
        end
        cyc_done = 0;

        // R6: disabled timer raises nothing
        tmr_en = 0;
        cyc_done = 1; cycle(); cyc_done = 0;
        for (int k = 0; k < 12; k++) cycle();
        chk("R6 disabled no req", int'(req), 0);

        // R8: period 0, fires every cycle, overrun saturates
        period = 16'd0; tmr_en = 1;
        for (int k = 0; k < 300; k++) cycle();
        chk("R8 saturated", int'(ovr_count), 255);
        tmr_en = 0;

        // R5: full row period from the seed
        do_reset();
        cyc_done = 1;
        for (int k = 0; k < 4096; k++) begin
            cycle();
            if (k < 4095) begin
                n_vec++;
                if (seen[addr[12:1]]) begin
                    n_bad++;
                    $display("FAIL R5 repeat: actual %0h expected unseen", addr[12:1]);
                end
                seen[addr[12:1]] = 1;
            end
        end
        cyc_done = 0;
        cycle();
        chk("R5 back to seed", int'(addr[12:1]), 12'hFFF);
        chk("R5 zero visited", int'(seen[0]), 1);
        chk("R5 seed unique", int'(seen[4095]), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule